// File: doc/BRIEF.md
# Phase Discriminator with Programmable-Lag Differentiator

This block accepts a stream of 18-bit phase words, one per cycle at most and marked by a valid strobe, for example from a rectangular-to-polar converter. Each accepted word is first multiplied by 1, 2, 4 or 8 through a left shift that drops the bits pushed past the top. This folds the phase onto a half, quarter or eighth of a turn so that binary, quaternary or eight-level phase keying is removed. The folded phase then passes through a differentiator. The differentiator subtracts the folded phase seen a programmable number of accepted samples earlier, from 1 to 8. The subtraction wraps modulo 2^18, so a step across the phase boundary yields the short signed difference.

A select input chooses whether the output carries the folded phase or its difference. A separate strobe-enable input forces the difference onto the output on every valid sample, with no external feedback path. The output is registered, so a result appears one clock after the sample that produced it. In difference mode no result is marked valid until the lag line holds enough samples for the chosen lag.

Top module: `phase_disc`

## Requirements
- R1: After reset is released (two clocks of synchronous release), out_valid is 0 and out_data is 0.
- R2: With cfg_out_sel = 0 and cfg_strobe_en = 0, a valid sample produces out_data = (in_phase << cfg_shift) mod 2^18, where cfg_shift is 0 to 3.
- R3: out_valid is 1 exactly one clock after an accepted in_valid cycle whose result is valid, and it is 0 in any cycle that follows a clock with in_valid low.
- R4: In difference mode, a valid result equals folded(n) - folded(n - L) mod 2^18. Here L = cfg_delay + 1, cfg_delay = 0 means a lag of 1 sample, and cfg_delay = 7 means a lag of 8 samples.
- R5: The difference wraps modulo 2^18. Folded 18'h3FFF0 followed by 18'h00010 at lag 1 gives 18'h00020, and the reverse order gives 18'h3FFE0.
- R6: The lag line advances only on cycles with in_valid high. Idle cycles between samples leave the differences unchanged.
- R7: After reset, in difference mode, results stay invalid until more than cfg_delay samples have been accepted. In phase mode, every sample is valid at once.
- R8: With cfg_strobe_en = 1, the output carries the difference whatever the value of cfg_out_sel.
- R9: out_data changes only in cycles where out_valid is 1. Otherwise it holds the last valid result.
- R10: Folding happens before the lag line. With cfg_shift = 2, phases that differ only by multiples of 18'h10000 give a difference of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Marks a phase sample on in_phase |
| in_phase | input | 18 | Unsigned phase, a full turn spans 2^18 |
| cfg_shift | input | 2 | Fold amount: shift left by 0 to 3 bits |
| cfg_delay | input | 3 | Differentiator lag minus one, in samples |
| cfg_out_sel | input | 1 | 1 selects the difference, 0 selects the folded phase |
| cfg_strobe_en | input | 1 | 1 forces the difference onto the output on every valid sample |
| out_valid | output | 1 | Result valid, one clock after the sample |
| out_data | output | 18 | Folded phase or its lagged difference |

## Verification
Assertions check the following on every cycle:
- out_valid never rises without an input sample in the cycle before.
- out_data holds whenever out_valid is low.
- The fill count of the lag line moves only with accepted samples and stays within its depth.
- A sample taken before priming never yields a valid difference.
- A forced-difference sample outputs the subtractor result.

The arithmetic itself needs the bench's scenarios, which compare the output against a model of the folded history. This covers the exact values for each fold amount and each of the eight lags, the boundary wrap, the cancellation of keyed phase steps, and the priming point right after reset.

// File: rtl/phase_disc_pkg.sv
package phase_disc_pkg;
  localparam int unsigned PH_W    = 18;
  localparam int unsigned MAX_LAG = 8;
  localparam int unsigned FOLD_W  = 2;
endpackage

// File: rtl/disc_fold.sv
module disc_fold #(
  parameter int unsigned W  = 18,
  parameter int unsigned SW = 2
) (
  input  logic [W-1:0]  phase_i,
  input  logic [SW-1:0] fold_i,
  output logic [W-1:0]  folded_o
);
  // Left shift into a W-bit result: upper bits drop, giving modulo 2^W / 2^fold
  always_comb begin
    folded_o = phase_i << fold_i;
  end
endmodule

// File: rtl/disc_lag_line.sv
module disc_lag_line #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic [LW-1:0] lag_i,
  output logic [W-1:0]  tap_o,
  output logic          primed_o
);
  logic [W-1:0]  stage_q [DEPTH];
  logic [W-1:0]  stage_d [DEPTH];
  logic [CW-1:0] fill_q, fill_d;

  // stage 0 holds the previous accepted sample, stage k the one k+1 back
  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        always_comb stage_d[gi] = push_i ? din_i : stage_q[gi];
      end else begin : g_body
        always_comb stage_d[gi] = push_i ? stage_q[gi-1] : stage_q[gi];
      end
      always_ff @(posedge clk) begin
        stage_q[gi] <= stage_d[gi];
      end
    end
  endgenerate

  always_comb begin
    fill_d = fill_q;
    if (push_i && (fill_q != CW'(DEPTH))) fill_d = fill_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  assign tap_o    = stage_q[lag_i];
  assign primed_o = fill_q > CW'(lag_i);

  a_r6_fill_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !push_i |=> $stable(fill_q));
  a_r6_head_load: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> (stage_q[0] == $past(din_i)));
  a_r7_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(DEPTH));
endmodule

// File: rtl/disc_sub.sv
module disc_sub #(
  parameter int unsigned W = 18
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] old_i,
  output logic [W-1:0] diff_o
);
  // modulo-2^W difference: read as signed, it is the short way round
  always_comb begin
    diff_o = cur_i - old_i;
  end
endmodule

// File: rtl/phase_disc.sv
module phase_disc
  import phase_disc_pkg::*;
#(
  parameter int unsigned W     = PH_W,
  parameter int unsigned DEPTH = MAX_LAG,
  parameter int unsigned SW    = FOLD_W,
  localparam int unsigned LW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_phase,
  input  logic [SW-1:0] cfg_shift,
  input  logic [LW-1:0] cfg_delay,
  input  logic          cfg_out_sel,
  input  logic          cfg_strobe_en,
  output logic          out_valid,
  output logic [W-1:0]  out_data
);
  logic [1:0]   rst_sync_q;
  logic         srst_n;
  logic [W-1:0] folded, tap, diff;
  logic         primed, deriv_sel;
  logic         valid_d;
  logic [W-1:0] data_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  disc_fold #(.W(W), .SW(SW)) u_fold (
    .phase_i (in_phase),
    .fold_i  (cfg_shift),
    .folded_o(folded)
  );

  disc_lag_line #(.W(W), .DEPTH(DEPTH)) u_lag (
    .clk     (clk),
    .rst_n   (srst_n),
    .push_i  (in_valid),
    .din_i   (folded),
    .lag_i   (cfg_delay),
    .tap_o   (tap),
    .primed_o(primed)
  );

  disc_sub #(.W(W)) u_sub (
    .cur_i (folded),
    .old_i (tap),
    .diff_o(diff)
  );

  assign deriv_sel = cfg_out_sel | cfg_strobe_en;

  always_comb begin
    valid_d = in_valid && (!deriv_sel || primed);
    data_d  = out_data;
    if (valid_d) data_d = deriv_sel ? diff : folded;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= valid_d;
      out_data  <= data_d;
    end
  end

  a_r3_valid_needs_input: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> $past(in_valid));
  a_r7_unprimed_blocked: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && deriv_sel && !primed) |=> !out_valid);
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!srst_n)
    !out_valid |-> $stable(out_data));
  a_r8_strobe_diff: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && cfg_strobe_en && primed) |=> (out_data == $past(diff)));
endmodule

// File: tb/phase_disc_tb.sv
module phase_disc_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [17:0] in_phase;
  logic [1:0]  cfg_shift;
  logic [2:0]  cfg_delay;
  logic        cfg_out_sel;
  logic        cfg_strobe_en;
  logic        out_valid;
  logic [17:0] out_data;

  int nchecks = 0;
  int nerr    = 0;
  bit done    = 0;

  logic [17:0] hist [8];
  int          cnt;
  logic [17:0] last;

  phase_disc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
    .cfg_shift(cfg_shift), .cfg_delay(cfg_delay), .cfg_out_sel(cfg_out_sel),
    .cfg_strobe_en(cfg_strobe_en), .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_phase = '0;
    cnt = 0; last = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", 18'(out_valid), 18'h0);
    check(out_data == 18'h0, "R1 data after reset", out_data, 18'h0);
  endtask

  // drive one sample at a falling edge, check the result one clock later
  task automatic push(input logic [17:0] ph, input string tag);
    logic [17:0] sh, ex;
    logic dsel, ev;
    sh   = ph << cfg_shift;
    dsel = cfg_out_sel | cfg_strobe_en;
    ev   = !dsel || (cnt > int'(cfg_delay));
    ex   = dsel ? (sh - hist[cfg_delay]) : sh;
    in_valid = 1'b1; in_phase = ph;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == ev, {tag, " valid"}, 18'(out_valid), 18'(ev));
    if (ev) begin
      check(out_data == ex, {tag, " data"}, out_data, ex);
      last = ex;
    end else begin
      check(out_data == last, {tag, " R9 hold"}, out_data, last);
    end
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = sh;
    if (cnt < 8) cnt++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R3 idle valid", 18'(out_valid), 18'h0);
      check(out_data == last, "R9 idle hold", out_data, last);
    end
  endtask

  task automatic t_phase_mode();
    do_reset();
    cfg_out_sel = 0; cfg_strobe_en = 0; cfg_delay = 3'd5;
    for (int s = 0; s < 4; s++) begin
      cfg_shift = 2'(s);
      push(18'h25A5C, "R2 fold R7 phase mode immediate");
      push(18'h3FFFF, "R2 fold top bits");
    end
  endtask

  task automatic t_priming();
    do_reset();
    cfg_shift = 0; cfg_out_sel = 1; cfg_strobe_en = 0; cfg_delay = 3'd3;
    for (int i = 0; i < 7; i++) push(18'(i * 18'h01111 + 18'h00123), "R7 priming R4 diff");
  endtask

  task automatic t_all_lags();
    cfg_shift = 0; cfg_out_sel = 1; cfg_strobe_en = 0;
    for (int d = 0; d < 8; d++) begin
      do_reset();
      cfg_delay = 3'(d);
      for (int i = 0; i < 11; i++) push(18'(i * i * 18'h01357 + d * 18'h00404), "R4 lag");
    end
  endtask

  task automatic t_wrap();
    do_reset();
    cfg_shift = 0; cfg_out_sel = 1; cfg_strobe_en = 0; cfg_delay = 3'd0;
    push(18'h3FFF0, "R5 wrap first");
    push(18'h00010, "R5 wrap up");
    check(out_data == 18'h00020, "R5 forward wrap", out_data, 18'h00020);
    push(18'h3FFF0, "R5 wrap down");
    check(out_data == 18'h3FFE0, "R5 backward wrap", out_data, 18'h3FFE0);
  endtask

  task automatic t_gaps();
    do_reset();
    cfg_shift = 2'd1; cfg_out_sel = 1; cfg_strobe_en = 0; cfg_delay = 3'd2;
    for (int i = 0; i < 8; i++) begin
      push(18'(i * 18'h02345 + 18'h00077), "R6 gapped diff");
      idle(i % 3 + 1);
    end
  endtask

  task automatic t_strobe();
    do_reset();
    cfg_shift = 0; cfg_out_sel = 0; cfg_strobe_en = 1; cfg_delay = 3'd1;
    for (int i = 0; i < 5; i++) push(18'(i * 18'h00900 + 18'h00011), "R8 strobe diff");
    check(out_data == 18'h01200, "R8 strobe lag 2 value", out_data, 18'h01200);
  endtask

  task automatic t_psk();
    do_reset();
    cfg_shift = 2'd2; cfg_out_sel = 1; cfg_strobe_en = 0; cfg_delay = 3'd0;
    push(18'h00005, "R10 prime");
    push(18'h10005, "R10 step");
    check(out_data == 18'h0, "R10 quarter step cancels", out_data, 18'h0);
    push(18'h30005, "R10 step");
    check(out_data == 18'h0, "R10 three quarter step cancels", out_data, 18'h0);
    push(18'h20006, "R10 residual");
    check(out_data == 18'h00004, "R10 residual kept", out_data, 18'h00004);
  endtask

  initial begin
    cfg_shift = 0; cfg_delay = 0; cfg_out_sel = 0; cfg_strobe_en = 0;
    for (int i = 0; i < 8; i++) hist[i] = '0;
    @(negedge clk);
    t_phase_mode();
    t_priming();
    t_all_lags();
    t_wrap();
    t_gaps();
    t_strobe();
    t_psk();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end
endmodule